// File: doc/BRIEF.md
# Card Command Issue Register Front-End

This block is the register-facing command and clock control section of a memory-card host controller. Software writes a command index, a 32-bit argument supplied as two 16-bit halves, a command/data control word, a clock-divider code and the timeout, block-length and block-count fields through a simple word-addressed write port. Every stored field can be read back on a combinational read port. The stored values are also presented to the card-side engine.

A start/stop register turns a clock-enable state on or off and keeps a clock-off flag. A command is handed to the card side as a one-cycle `launch_o` pulse in one of two ways. The first is a control-word write while the clock runs. The second is a clock start while a command is pending. A stop-transfer bit in the control word holds back both ways. Card signalling, CRC and the data path sit outside this block.

Top module: `card_cmd_frontend`

## Requirements
- R1: After reset every stored field, the clock-enable state, the clock-off flag and `launch_o` are zero. Reads return zero everywhere except the command index word at offset 0x30, which reads 0x40.
- R2: A write to offset 0x00 with bit 1 set turns the clock on (status at offset 0x04 reads bit 8 set) and clears the clock-off flag. A write with bit 0 set turns the clock off and sets the clock-off flag. When both bits are set, the clock ends off and the flag ends set.
- R3: A write to offset 0x10 stores the value ANDed with 0x3DFF, shows it on `cmd_ctrl_o` and reads it back, and marks a command as pending.
- R4: A write to offset 0x10 with bit 10 clear while the clock is on drives `launch_o` high for exactly the cycle after the write. The pending mark is then consumed.
- R5: A control write while the clock is off gives no launch. A later write of bit 1 to offset 0x00 launches the pending command in the cycle after that write. A further start write gives no launch.
- R6: While control bit 10 (stop-transfer) is set, neither a control write nor a clock start launches a command.
- R7: Stored widths: clock divider 3 bits at 0x08, mode field 4 bits at 0x0C, response timeout 7 bits at 0x14, read timeout 16 bits at 0x18, block length 12 bits at 0x1C, block count 16 bits at 0x20. Each takes the low bits of the written value and reads back zero-extended.
- R8: Offset 0x30 stores a 6-bit command index, shown on `cmd_idx_o`. It reads back as the index ORed with 0x40.
- R9: A write to offset 0x34 replaces argument bits 31:16 with the written bits 15:0. A write to offset 0x38 replaces bits 15:0. The other half is kept in both cases. Offset 0x34 reads bits 31:16, offset 0x38 reads bits 15:0, and `cmd_arg_o` shows all 32 bits.
- R10: Writes to any other offset, including the read-only status at 0x04, change no state and launch nothing. Reads of offsets that hold no field return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| launch_o | output | 1 | One-cycle command launch pulse |
| cmd_idx_o | output | 6 | Stored command index |
| cmd_arg_o | output | 32 | Stored command argument |
| cmd_ctrl_o | output | 14 | Stored command/data control word |
| clk_en_o | output | 1 | Card clock enable state |
| clk_off_o | output | 1 | Clock-off event flag |

## Verification
A wrong pending mark shows up only on `launch_o`. It gives an extra pulse or a missing pulse in the cycle after the next clock-start write, so the bench checks the launch output on both sides of every start and control write. A corrupted field mask or argument merge shows up on the very next read of that offset. For that reason every field is written with several patterns and read back at once. Writes to unused offsets are followed by a full readback of all offsets, so a stray decode shows up within the same sweep.

// File: rtl/cmd_fe_pkg.sv
package cmd_fe_pkg;
  localparam int unsigned OFF_CLKCTL = 'h00;
  localparam int unsigned OFF_STATUS = 'h04;
  localparam int unsigned OFF_CLKDIV = 'h08;
  localparam int unsigned OFF_MODE   = 'h0C;
  localparam int unsigned OFF_CTRL   = 'h10;
  localparam int unsigned OFF_RSPTO  = 'h14;
  localparam int unsigned OFF_RDTO   = 'h18;
  localparam int unsigned OFF_BLKLEN = 'h1C;
  localparam int unsigned OFF_BLKCNT = 'h20;
  localparam int unsigned OFF_CMD    = 'h30;
  localparam int unsigned OFF_ARGHI  = 'h34;
  localparam int unsigned OFF_ARGLO  = 'h38;

  localparam int unsigned IDX_W    = 6;
  localparam int unsigned ARG_W    = 32;
  localparam int unsigned HALF_W   = ARG_W / 2;
  localparam int unsigned CTRL_W   = 14;
  localparam int unsigned DIV_W    = 3;
  localparam int unsigned MODE_W   = 4;
  localparam int unsigned RSPTO_W  = 7;
  localparam int unsigned RDTO_W   = 16;
  localparam int unsigned BLKLEN_W = 12;
  localparam int unsigned BLKCNT_W = 16;

  localparam logic [CTRL_W-1:0] CTRL_KEEP = 14'h3DFF;
  localparam int unsigned STOPTRAN_BIT = 10;
  localparam int unsigned START_BIT    = 1;
  localparam int unsigned STOP_BIT     = 0;
  localparam int unsigned STAT_CLK_BIT = 8;
  localparam logic [31:0] CMD_RD_FLAG  = 32'h40;

  typedef struct packed {
    logic [IDX_W-1:0]    cmd_idx;
    logic [ARG_W-1:0]    arg;
    logic [CTRL_W-1:0]   ctrl;
    logic [DIV_W-1:0]    clk_div;
    logic [MODE_W-1:0]   mode;
    logic [RSPTO_W-1:0]  rsp_to;
    logic [RDTO_W-1:0]   rd_to;
    logic [BLKLEN_W-1:0] blk_len;
    logic [BLKCNT_W-1:0] blk_cnt;
  } cfg_t;
endpackage

// File: rtl/cmd_fe_regfile.sv
module cmd_fe_regfile
  import cmd_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      if (hit(addr_i, OFF_CMD))    cfg_q.cmd_idx <= wdata_i[IDX_W-1:0];
      if (hit(addr_i, OFF_ARGHI))  cfg_q.arg[ARG_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
      if (hit(addr_i, OFF_ARGLO))  cfg_q.arg[HALF_W-1:0] <= wdata_i[HALF_W-1:0];
      if (hit(addr_i, OFF_CTRL))   cfg_q.ctrl <= wdata_i[CTRL_W-1:0] & CTRL_KEEP;
      if (hit(addr_i, OFF_CLKDIV)) cfg_q.clk_div <= wdata_i[DIV_W-1:0];
      if (hit(addr_i, OFF_MODE))   cfg_q.mode <= wdata_i[MODE_W-1:0];
      if (hit(addr_i, OFF_RSPTO))  cfg_q.rsp_to <= wdata_i[RSPTO_W-1:0];
      if (hit(addr_i, OFF_RDTO))   cfg_q.rd_to <= wdata_i[RDTO_W-1:0];
      if (hit(addr_i, OFF_BLKLEN)) cfg_q.blk_len <= wdata_i[BLKLEN_W-1:0];
      if (hit(addr_i, OFF_BLKCNT)) cfg_q.blk_cnt <= wdata_i[BLKCNT_W-1:0];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cmd_fe_launch.sv
module cmd_fe_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,    // control word written this cycle
  input  logic ctrl_hold_i,  // stop-transfer bit of the word being written
  input  logic clkctl_wr_i,  // start/stop register written this cycle
  input  logic start_i,
  input  logic stop_i,
  input  logic held_i,       // stop-transfer bit of the stored word
  output logic launch_o,
  output logic clk_en_o,
  output logic clk_off_o
);
  logic pend_q, clk_en_q, clk_off_q, launch_q;
  logic fire_ctrl, fire_clk, fire;

  assign fire_ctrl = ctrl_wr_i && !ctrl_hold_i && clk_en_q;
  assign fire_clk  = clkctl_wr_i && start_i && pend_q && !held_i;
  assign fire      = fire_ctrl || fire_clk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      clk_en_q  <= 1'b0;
      clk_off_q <= 1'b0;
      launch_q  <= 1'b0;
    end else begin
      launch_q <= fire;
      if (fire)           pend_q <= 1'b0;
      else if (ctrl_wr_i) pend_q <= 1'b1;
      if (clkctl_wr_i) begin
        // stop wins when both bits are written
        if (stop_i) begin
          clk_en_q  <= 1'b0;
          clk_off_q <= 1'b1;
        end else if (start_i) begin
          clk_en_q  <= 1'b1;
          clk_off_q <= 1'b0;
        end
      end
    end
  end

  assign launch_o  = launch_q;
  assign clk_en_o  = clk_en_q;
  assign clk_off_o = clk_off_q;
endmodule

// File: rtl/cmd_fe_rdmux.sv
module cmd_fe_rdmux
  import cmd_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  cfg_t              cfg_i,
  input  logic              clk_en_i,
  output logic [31:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_STATUS)) rdata_o[STAT_CLK_BIT] = clk_en_i;
    if (addr_i == ADDR_W'(OFF_CLKDIV)) rdata_o = 32'(cfg_i.clk_div);
    if (addr_i == ADDR_W'(OFF_MODE))   rdata_o = 32'(cfg_i.mode);
    if (addr_i == ADDR_W'(OFF_CTRL))   rdata_o = 32'(cfg_i.ctrl);
    if (addr_i == ADDR_W'(OFF_RSPTO))  rdata_o = 32'(cfg_i.rsp_to);
    if (addr_i == ADDR_W'(OFF_RDTO))   rdata_o = 32'(cfg_i.rd_to);
    if (addr_i == ADDR_W'(OFF_BLKLEN)) rdata_o = 32'(cfg_i.blk_len);
    if (addr_i == ADDR_W'(OFF_BLKCNT)) rdata_o = 32'(cfg_i.blk_cnt);
    if (addr_i == ADDR_W'(OFF_CMD))    rdata_o = 32'(cfg_i.cmd_idx) | CMD_RD_FLAG;
    if (addr_i == ADDR_W'(OFF_ARGHI))  rdata_o = 32'(cfg_i.arg[ARG_W-1:HALF_W]);
    if (addr_i == ADDR_W'(OFF_ARGLO))  rdata_o = 32'(cfg_i.arg[HALF_W-1:0]);
  end
endmodule

// File: rtl/card_cmd_frontend.sv
module card_cmd_frontend
  import cmd_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              launch_o,
  output logic [5:0]        cmd_idx_o,
  output logic [31:0]       cmd_arg_o,
  output logic [13:0]       cmd_ctrl_o,
  output logic              clk_en_o,
  output logic              clk_off_o
);
  cfg_t cfg;
  logic ctrl_wr, clkctl_wr;

  assign ctrl_wr   = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign clkctl_wr = wr_en_i && (addr_i == ADDR_W'(OFF_CLKCTL));

  cmd_fe_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .cfg_o  (cfg)
  );

  cmd_fe_launch u_launch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .ctrl_hold_i(wdata_i[STOPTRAN_BIT]),
    .clkctl_wr_i(clkctl_wr),
    .start_i    (wdata_i[START_BIT]),
    .stop_i     (wdata_i[STOP_BIT]),
    .held_i     (cfg.ctrl[STOPTRAN_BIT]),
    .launch_o   (launch_o),
    .clk_en_o   (clk_en_o),
    .clk_off_o  (clk_off_o)
  );

  cmd_fe_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr_i  (addr_i),
    .cfg_i   (cfg),
    .clk_en_i(clk_en_o),
    .rdata_o (rdata_o)
  );

  assign cmd_idx_o  = cfg.cmd_idx;
  assign cmd_arg_o  = cfg.arg;
  assign cmd_ctrl_o = cfg.ctrl;
endmodule

// File: rtl/cmd_fe_checker.sv
module cmd_fe_checker
  import cmd_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              launch_o,
  input logic              clk_en_o,
  input logic              clk_off_o,
  input logic [13:0]       cmd_ctrl_o
);
  logic ctl_wr, clk_wr;
  assign ctl_wr = wr_en_i && addr_i == ADDR_W'(OFF_CTRL);
  assign clk_wr = wr_en_i && addr_i == ADDR_W'(OFF_CLKCTL);

  AST_CLK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_wr && wdata_i[START_BIT] && !wdata_i[STOP_BIT] |=> clk_en_o && !clk_off_o); // R2
  AST_CLK_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_wr && wdata_i[STOP_BIT] |=> !clk_en_o && clk_off_o); // R2
  AST_CLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_wr |=> $stable(clk_en_o) && $stable(clk_off_o)); // R10
  AST_CTRL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> cmd_ctrl_o == (wdata_i[13:0] & CTRL_KEEP)); // R3
  AST_CTRL_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && !wdata_i[STOPTRAN_BIT] && clk_en_o |=> launch_o); // R4
  AST_OFF_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && !clk_en_o |=> !launch_o); // R5
  AST_HOLD_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && wdata_i[STOPTRAN_BIT] |=> !launch_o); // R6
  AST_IDLE_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_wr || clk_wr) |=> !launch_o); // R10
endmodule

bind card_cmd_frontend cmd_fe_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/card_cmd_frontend_tb.sv
module card_cmd_frontend_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, arg;
  logic launch, clk_en, clk_off;
  logic [5:0] idx;
  logic [13:0] ctrl;

  int n_chk = 0, n_fail = 0;

  // model
  logic [31:0] m_val [0:19];
  logic [31:0] m_arg = '0;
  logic m_clk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cmd_frontend #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .launch_o(launch), .cmd_idx_o(idx), .cmd_arg_o(arg),
    .cmd_ctrl_o(ctrl), .clk_en_o(clk_en), .clk_off_o(clk_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fmask(input int w);
    case (w)
      2: return 32'h7;       3: return 32'hF;    4: return 32'h3DFF;
      5: return 32'h7F;      6: return 32'hFFFF; 7: return 32'hFFF;
      8: return 32'hFFFF;    12: return 32'h3F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int w);
    case (w)
      1: return {23'h0, m_clk, 8'h0};
      12: return m_val[12] | 32'h40;
      13: return {16'h0, m_arg[31:16]};
      14: return {16'h0, m_arg[15:0]};
      default: return m_val[w];
    endcase
  endfunction

  function automatic string req_of(input int w);
    case (w)
      1: return "R2";  4: return "R3";  12: return "R8";
      13, 14: return "R9";
      2, 3, 5, 6, 7, 8: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(off); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (off == 52) m_arg[31:16] = d[15:0];
    else if (off == 56) m_arg[15:0] = d[15:0];
    else if (off != 0 && off < 80) m_val[off/4] = d & fmask(off/4);
  endtask

  task automatic rd_chk(input int w, input string req);
    addr = AW'(w*4);
    #1;
    chk(req, rdata, exp_rd(w));
  endtask

  task automatic launch_chk(input string req, input logic exp);
    chk(req, 32'(launch), 32'(exp));
    @(negedge clk);
    chk(req, 32'(launch), 32'h0);  // pulse is single cycle
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20; i++) m_val[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int w = 0; w < 20; w++) rd_chk(w, "R1");
    chk("R1", {launch, clk_en, clk_off}, 32'h0);
    chk("R1", arg, 32'h0);

    // field sweep, clock off so control writes only mark pending (R5)
    begin
      automatic int offs[10] = '{8, 12, 16, 20, 24, 28, 32, 48, 52, 56};
      automatic logic [31:0] pats[3] = '{32'hFFFF_FFFF, 32'h5A5A_A5A5, 32'h0000_0000};
      for (int p = 0; p < 3; p++) begin
        for (int k = 0; k < 10; k++) begin
          wr(offs[k], pats[p] ^ (32'h0001_0001 * 32'(k)));
          chk("R5", 32'(launch), 32'h0);
          rd_chk(offs[k]/4, req_of(offs[k]/4));
        end
      end
    end
    chk("R9", arg, m_arg);
    chk("R8", 32'(idx), m_val[12]);
    chk("R3", 32'(ctrl), m_val[4]);

    // distinct argument halves
    wr(52, 32'hFFFF_BEEF); wr(56, 32'h1234_C0DE);
    chk("R9", arg, 32'hBEEF_C0DE);
    wr(56, 32'h0000_0001);
    chk("R9", arg, 32'hBEEF_0001);

    // R10: writes to offsets without a writable field
    for (int w = 0; w < 20; w++) begin
      if (w == 1 || w == 9 || w == 10 || w == 11 || w >= 15) begin
        wr(w*4, 32'hFFFF_FFFF);
        chk("R10", {launch, clk_en, clk_off}, 32'h0);
        for (int v = 0; v < 20; v++) rd_chk(v, req_of(v));
      end
    end

    // pending control word (last sweep value bit 10 clear): start launches (R5)
    wr(16, 32'h0000_0005);
    chk("R5", 32'(launch), 32'h0);
    wr(0, 32'h2); m_clk = 1'b1;
    launch_chk("R5", 1'b1);
    chk("R2", {clk_en, clk_off}, 32'h2);
    rd_chk(1, "R2");
    wr(0, 32'h2);
    launch_chk("R5", 1'b0);

    // R4: control write while running
    wr(16, 32'hFFFF_C041);
    launch_chk("R4", 1'b1);
    chk("R3", 32'(ctrl), 32'h0041);
    wr(16, 32'h0000_0003);
    launch_chk("R4", 1'b1);

    // R6: stop-transfer holds both paths
    wr(16, 32'h0000_0401);
    launch_chk("R6", 1'b0);
    wr(0, 32'h2);
    launch_chk("R6", 1'b0);

    // R2: stop, then R5 again, then combined start+stop
    wr(0, 32'h1); m_clk = 1'b0;
    chk("R2", {clk_en, clk_off}, 32'h1);
    rd_chk(1, "R2");
    wr(16, 32'h0000_0003);
    launch_chk("R5", 1'b0);
    wr(0, 32'h3);
    launch_chk("R2", 1'b1);
    chk("R2", {clk_en, clk_off}, 32'h1);
    wr(0, 32'h2); m_clk = 1'b1;
    launch_chk("R5", 1'b0);
    chk("R2", {clk_en, clk_off}, 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule